// File: doc/BRIEF.md
# Host Marker Completion Poller

This controller decides when a launched batch of memory-copy descriptors has finished. No completion queue is used. Before launch, software stores a 32-bit sentinel (0xABCDEF01) in word 0 of a two-word buffer in host memory and clears word 1, the poll slot. The copy engine executes a last self-copy descriptor that moves word 0 into word 1. The poller therefore declares completion when word 1 reads back as the sentinel.

A start command carries the descriptor count of the batch and three mode flags: emulation platform, synchronous intra-device copy, and architecture generation. From these the poller derives two values. The first is a first-wait delay. The second is a poll budget, which grows with the descriptor count and with the platform mode. After the first wait, the poller reads the poll slot once per microsecond tick. On a match it clears the poll slot, re-seeds word 0 with the sentinel, and raises an acknowledge, first for the receive ring and then for the transmit ring, each carrying the batch count. If the budget runs out first, it reports a timeout and sends no acknowledge.

Top module: `marker_poller`

## Requirements
- R1: After synchronous reset, `done`, `timeout`, `busy`, `busy_err`, `ack_valid` and `mem_req` are all 0.
- R2: A poll is a read with `mem_addr`=1 (byte offset +4). A read is issued only in the cycle after a `tick` pulse, and at most one read is outstanding. The returned word is compared only in the cycle in which `mem_rvalid` is 1.
- R3: The estimate is `est` = 4×(count−1) when `start_gen`=0 and 2×(count−1) when `start_gen`=1, with `est`=0 for count 0. The first wait is `est` ticks, or 10 ticks when `start_d2d`=1. The first poll is made on tick number first_wait+1 after start.
- R4: The budget is `est`, multiplied by 100000 when `start_emu`=1, then divided by 200 (rounded down) when `start_d2d`=1. At most budget+1 polls are made.
- R5: When a poll returns 0xABCDEF01, two writes follow in this order: 0 to word 1 (`mem_addr`=1), then 0xABCDEF01 to word 0 (`mem_addr`=0).
- R6: After those writes, `ack_valid` is high for exactly two consecutive cycles. The first cycle has `ack_ring`=0 (receive) and the second has `ack_ring`=1 (transmit). Both carry `ack_count` equal to the started count. `done` rises in the cycle after the transmit acknowledge.
- R7: If poll number budget+1 also mismatches, `timeout` is set. No write is made and no acknowledge is issued.
- R8: `done` and `timeout` are never both 1. Each holds until the next accepted start.
- R9: A `start` that arrives while `busy` is 1 is ignored: the running count, limit and outcome do not change. It produces a one-cycle `busy_err` pulse.
- R10: A match on the final allowed poll (number budget+1) ends with `done` and not with `timeout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch-watch command, one cycle |
| start_count | input | CNT_W | Descriptors in the batch |
| start_emu | input | 1 | Emulation platform flag |
| start_d2d | input | 1 | Synchronous intra-device copy flag |
| start_gen | input | 1 | Architecture generation (0: 4 µs/desc, 1: 2 µs/desc) |
| tick | input | 1 | One-cycle pulse each microsecond |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 1 | Word index in marker buffer |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| mem_rvalid | input | 1 | Read data valid |
| ack_valid | output | 1 | Ring acknowledge strobe |
| ack_ring | output | 1 | 0 = receive ring, 1 = transmit ring |
| ack_count | output | CNT_W | Slots to recycle |
| busy | output | 1 | A watch is in progress |
| busy_err | output | 1 | Pulse: start ignored while busy |
| done | output | 1 | Sticky completion status |
| timeout | output | 1 | Sticky timeout status |

## Verification
A wrong latched first wait or poll limit shows up at the ports as a change in the tick on which the first read appears, or in the number of reads made before `timeout`. This is visible within one operation, so the bench counts reads and ticks for every mode combination and compares them with the arithmetic. A sequencing fault after a match would appear within six cycles of the matching read: wrong write order, a missing re-seed, or acknowledges with the rings swapped or the count wrong. A start that is wrongly accepted while busy changes the acknowledged count or the poll total of the running operation.

// File: rtl/mp_pkg.sv
package mp_pkg;
  localparam logic [31:0] SENTINEL = 32'hABCD_EF01;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_CLR_SLOT,
    ST_RESEED,
    ST_ACK_RX,
    ST_ACK_TX
  } poll_state_t;
endpackage

// File: rtl/mp_budget.sv
module mp_budget #(
  parameter int CNT_W     = 12,
  parameter int GEN0_MUL  = 4,
  parameter int GEN1_MUL  = 2,
  parameter int EMU_SCALE = 100000,
  parameter int D2D_DIV   = 200,
  parameter int D2D_FIRST = 10,
  localparam int EST_W = CNT_W + 3,
  localparam int LIM_W = EST_W + $clog2(EMU_SCALE) + 1
) (
  input  logic [CNT_W-1:0] count,
  input  logic             emu,
  input  logic             d2d,
  input  logic             gen,
  output logic [EST_W-1:0] first_wait,
  output logic [LIM_W-1:0] limit
);
  logic [EST_W-1:0] est;
  logic [EST_W-1:0] mul;
  logic [LIM_W-1:0] scaled;
  logic [LIM_W-1:0] bud;

  always_comb begin
    mul = gen ? EST_W'(GEN1_MUL) : EST_W'(GEN0_MUL);
    if (count == '0)
      est = '0;
    else
      est = mul * EST_W'(count - 1'b1);
    scaled     = emu ? LIM_W'(est) * LIM_W'(EMU_SCALE) : LIM_W'(est);
    bud        = d2d ? scaled / LIM_W'(D2D_DIV) : scaled;
    limit      = bud + LIM_W'(1);
    first_wait = d2d ? EST_W'(D2D_FIRST) : est;
  end
endmodule

// File: rtl/mp_poll_fsm.sv
module mp_poll_fsm
  import mp_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int EST_W = CNT_W + 3,
  parameter int LIM_W = 33
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] start_count,
  input  logic [EST_W-1:0] first_wait,
  input  logic [LIM_W-1:0] limit,
  input  logic             tick,
  output logic             mem_req,
  output logic             mem_we,
  output logic             mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_rvalid,
  output logic             ack_valid,
  output logic             ack_ring,
  output logic [CNT_W-1:0] ack_count,
  output logic             busy,
  output logic             busy_err,
  output logic             done,
  output logic             timeout
);
  poll_state_t      state;
  logic [CNT_W-1:0] cnt_q;
  logic [EST_W-1:0] fw_q;
  logic [LIM_W-1:0] lim_q;
  logic [LIM_W-1:0] polls_q;
  logic             done_q, to_q, berr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt_q   <= '0;
      fw_q    <= '0;
      lim_q   <= '0;
      polls_q <= '0;
      done_q  <= 1'b0;
      to_q    <= 1'b0;
      berr_q  <= 1'b0;
    end else begin
      berr_q <= start && (state != ST_IDLE);
      case (state)
        ST_IDLE: if (start) begin
          cnt_q   <= start_count;
          fw_q    <= first_wait;
          lim_q   <= limit;
          polls_q <= '0;
          done_q  <= 1'b0;
          to_q    <= 1'b0;
          state   <= ST_WAIT;
        end
        ST_WAIT: if (tick) begin
          if (fw_q == '0) state <= ST_RD_REQ;
          else            fw_q  <= fw_q - 1'b1;
        end
        ST_RD_REQ: state <= ST_RD_WAIT;
        ST_RD_WAIT: if (mem_rvalid) begin
          if (mem_rdata == SENTINEL) begin
            state <= ST_CLR_SLOT;
          end else if ((polls_q + LIM_W'(1)) == lim_q) begin
            to_q  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            polls_q <= polls_q + LIM_W'(1);
            state   <= ST_WAIT;
          end
        end
        ST_CLR_SLOT: state <= ST_RESEED;
        ST_RESEED:   state <= ST_ACK_RX;
        ST_ACK_RX:   state <= ST_ACK_TX;
        ST_ACK_TX: begin
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_req   = (state == ST_RD_REQ) || (state == ST_CLR_SLOT) || (state == ST_RESEED);
  assign mem_we    = (state == ST_CLR_SLOT) || (state == ST_RESEED);
  assign mem_addr  = (state != ST_RESEED);
  assign mem_wdata = (state == ST_RESEED) ? SENTINEL : 32'd0;
  assign ack_valid = (state == ST_ACK_RX) || (state == ST_ACK_TX);
  assign ack_ring  = (state == ST_ACK_TX);
  assign ack_count = cnt_q;
  assign busy      = (state != ST_IDLE);
  assign busy_err  = berr_q;
  assign done      = done_q;
  assign timeout   = to_q;

  // R2: a poll read only follows a tick, and never two reads back to back
  assert_read_after_tick_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> $past(tick));
  assert_one_outstanding_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |=> !(mem_req && !mem_we));
  // R5: the re-seed of word 0 directly follows clearing the poll slot
  assert_clear_before_reseed_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && !mem_addr) |-> $past(mem_req && mem_we && mem_addr && mem_wdata == 32'd0));
  // R6: transmit acknowledge directly follows receive acknowledge, same count
  assert_rx_before_tx_R6: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && ack_ring) |-> ($past(ack_valid && !ack_ring) && $stable(ack_count)));
  assert_done_after_ack_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(ack_valid && ack_ring));
  // R7: timeout only rises right after a returned poll word
  assert_timeout_on_read_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout) |-> $past(mem_rvalid && state == ST_RD_WAIT));
  // R8: exclusive status
  assert_status_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(done && timeout));
  // R9: busy error only for a start seen while busy
  assert_busy_err_cause_R9: assert property (@(posedge clk) disable iff (rst)
    busy_err |-> $past(start && busy));
endmodule

// File: rtl/marker_poller.sv
module marker_poller #(
  parameter int CNT_W     = 12,
  parameter int GEN0_MUL  = 4,
  parameter int GEN1_MUL  = 2,
  parameter int EMU_SCALE = 100000,
  parameter int D2D_DIV   = 200,
  parameter int D2D_FIRST = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] start_count,
  input  logic             start_emu,
  input  logic             start_d2d,
  input  logic             start_gen,
  input  logic             tick,
  output logic             mem_req,
  output logic             mem_we,
  output logic             mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_rvalid,
  output logic             ack_valid,
  output logic             ack_ring,
  output logic [CNT_W-1:0] ack_count,
  output logic             busy,
  output logic             busy_err,
  output logic             done,
  output logic             timeout
);
  localparam int EST_W = CNT_W + 3;
  localparam int LIM_W = EST_W + $clog2(EMU_SCALE) + 1;

  logic [EST_W-1:0] fw_w;
  logic [LIM_W-1:0] lim_w;

  mp_budget #(
    .CNT_W(CNT_W), .GEN0_MUL(GEN0_MUL), .GEN1_MUL(GEN1_MUL),
    .EMU_SCALE(EMU_SCALE), .D2D_DIV(D2D_DIV), .D2D_FIRST(D2D_FIRST)
  ) u_budget (
    .count(start_count), .emu(start_emu), .d2d(start_d2d), .gen(start_gen),
    .first_wait(fw_w), .limit(lim_w)
  );

  mp_poll_fsm #(.CNT_W(CNT_W), .EST_W(EST_W), .LIM_W(LIM_W)) u_fsm (
    .clk(clk), .rst(rst), .start(start), .start_count(start_count),
    .first_wait(fw_w), .limit(lim_w), .tick(tick),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
    .ack_valid(ack_valid), .ack_ring(ack_ring), .ack_count(ack_count),
    .busy(busy), .busy_err(busy_err), .done(done), .timeout(timeout)
  );
endmodule

// File: tb/test_marker_poller.sv
module test_marker_poller;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 12;
  localparam logic [31:0] SENT = 32'hABCD_EF01;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [CNT_W-1:0] start_count = '0;
  logic start_emu = 1'b0, start_d2d = 1'b0, start_gen = 1'b0, tick = 1'b0;
  logic mem_req, mem_we, mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic mem_rvalid = 1'b0;
  logic ack_valid, ack_ring, busy, busy_err, done, timeout;
  logic [CNT_W-1:0] ack_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  marker_poller #(.CNT_W(CNT_W)) i_marker_poller (
    .clk(clk), .rst(rst), .start(start), .start_count(start_count),
    .start_emu(start_emu), .start_d2d(start_d2d), .start_gen(start_gen), .tick(tick),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
    .ack_valid(ack_valid), .ack_ring(ack_ring), .ack_count(ack_count),
    .busy(busy), .busy_err(busy_err), .done(done), .timeout(timeout)
  );

  // host memory model with bench seeding port
  logic [31:0] hmem [2];
  logic seed_en = 1'b0, seed_addr = 1'b0;
  logic [31:0] seed_data = '0;
  int reads = 0, writes = 0, acks = 0;
  logic [32:0] wr_last = '0, wr_prev = '0;
  logic [CNT_W:0] ack_last = '0, ack_prev = '0;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (seed_en) hmem[seed_addr] <= seed_data;
    if (mem_req && mem_we) begin
      hmem[mem_addr] <= mem_wdata;
      writes  <= writes + 1;
      wr_prev <= wr_last;
      wr_last <= {mem_addr, mem_wdata};
    end else if (mem_req) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= hmem[mem_addr];
      reads      <= reads + 1;
    end
    if (ack_valid) begin
      acks     <= acks + 1;
      ack_prev <= ack_last;
      ack_last <= {ack_ring, ack_count};
    end
  end

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic seed(input logic a, input logic [31:0] d);
    @(negedge clk); seed_en = 1'b1; seed_addr = a; seed_data = d;
    @(negedge clk); seed_en = 1'b0;
  endtask

  task automatic do_start(input int c, input bit emu, input bit d2d, input bit gen);
    @(negedge clk);
    start = 1'b1; start_count = CNT_W'(c); start_emu = emu; start_d2d = d2d; start_gen = gen;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic one_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    repeat (7) @(negedge clk);
  endtask

  // hit_at = poll number returning the sentinel (0: never)
  task automatic run_ticks(input longint hit_at, input int rbase,
                           output longint polls, output longint fw_obs);
    int t = 0;
    bit seeded = 1'b0;
    fw_obs = -1;
    while (!(done || timeout) && t < 5000) begin
      if (hit_at != 0 && !seeded && longint'(reads - rbase) == hit_at - 1) begin
        seed(1'b1, SENT);
        seeded = 1'b1;
      end
      one_tick();
      t++;
      if (fw_obs < 0 && reads != rbase) fw_obs = t;
    end
    polls = reads - rbase;
  endtask

  function automatic longint est_of(input int c, input bit gen);
    if (c == 0) return 0;
    return longint'(gen ? 2 : 4) * longint'(c - 1);
  endfunction

  function automatic longint limit_of(input int c, input bit emu, input bit d2d, input bit gen);
    longint b = est_of(c, gen);
    if (emu) b = b * 100000;
    if (d2d) b = b / 200;
    return b + 1;
  endfunction

  function automatic longint fw_of(input int c, input bit d2d, input bit gen);
    return d2d ? 10 : est_of(c, gen);
  endfunction

  // full operation; hit_at 0 expects timeout
  task automatic op(input string tag, input int c, input bit emu, input bit d2d, input bit gen,
                    input longint hit_at);
    int rb, wb, ab;
    longint polls, fwo;
    seed(1'b0, 32'd0);
    seed(1'b1, 32'd0);
    rb = reads; wb = writes; ab = acks;
    do_start(c, emu, d2d, gen);
    run_ticks(hit_at, rb, polls, fwo);
    check({tag, " R3 first poll tick"}, fwo, fw_of(c, d2d, gen) + 1);
    if (hit_at == 0) begin
      check({tag, " R4 poll count"}, polls, limit_of(c, emu, d2d, gen));
      check({tag, " R7 timeout"}, timeout, 1);
      check({tag, " R7 no ack"}, acks - ab, 0);
      check({tag, " R7 no write"}, writes - wb, 0);
      check({tag, " R8 done low"}, done, 0);
    end else begin
      check({tag, " R2 polls to match"}, polls, hit_at);
      check({tag, " R10 done"}, done, 1);
      check({tag, " R8 timeout low"}, timeout, 0);
      check({tag, " R5 two writes"}, writes - wb, 2);
      check({tag, " R5 first clears slot"}, longint'(wr_prev), longint'({1'b1, 32'd0}));
      check({tag, " R5 second reseeds"}, longint'(wr_last), longint'({1'b0, SENT}));
      check({tag, " R5 word0"}, hmem[0], SENT);
      check({tag, " R5 word1"}, hmem[1], 0);
      check({tag, " R6 two acks"}, acks - ab, 2);
      check({tag, " R6 rx first"}, longint'(ack_prev), longint'({1'b0, CNT_W'(c)}));
      check({tag, " R6 tx second"}, longint'(ack_last), longint'({1'b1, CNT_W'(c)}));
    end
  endtask

  initial begin
    int rb;
    longint polls, fwo;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 done", done, 0);
    check("R1 timeout", timeout, 0);
    check("R1 busy", busy, 0);
    check("R1 ack_valid", ack_valid, 0);
    check("R1 mem_req", mem_req, 0);
    check("R1 busy_err", busy_err, 0);

    // timeout sweep over counts and generations
    for (int g = 0; g < 2; g++)
      for (int c = 0; c < 5; c++)
        op($sformatf("to g%0d c%0d", g, c), c, 1'b0, 1'b0, g[0], 0);

    // matches on first and on final allowed poll
    for (int g = 0; g < 2; g++)
      for (int c = 1; c < 4; c++) begin
        op($sformatf("hit1 g%0d c%0d", g, c), c, 1'b0, 1'b0, g[0], 1);
        op($sformatf("hitlast g%0d c%0d", g, c), c, 1'b0, 1'b0, g[0],
           limit_of(c, 1'b0, 1'b0, g[0]));
      end

    // intra-device: budget/200, first wait 10
    op("d2d g0 c401", 401, 1'b0, 1'b1, 1'b0, 0);
    op("d2d hit g1 c5", 5, 1'b0, 1'b1, 1'b1, 1);
    // emulation + intra-device: 2*100000/200 = 1000
    op("emu d2d g1 c2", 2, 1'b1, 1'b1, 1'b1, 0);
    // emulation alone: survives far past the plain limit of 5
    op("emu g0 c2", 2, 1'b1, 1'b0, 1'b0, 50);

    // R9: start while busy is ignored
    seed(1'b0, 32'd0);
    seed(1'b1, 32'd0);
    rb = reads;
    do_start(3, 1'b0, 1'b0, 1'b0);
    one_tick();
    @(negedge clk); start = 1'b1; start_count = CNT_W'(7); start_gen = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R9 busy_err pulse", busy_err, 1);
    @(negedge clk);
    check("R9 busy_err one cycle", busy_err, 0);
    check("R9 still busy", busy, 1);
    run_ticks(0, rb, polls, fwo);
    check("R9 original limit kept", polls, 9);
    check("R9 timeout", timeout, 1);
    // R8: sticky status, cleared by next start
    repeat (5) @(negedge clk);
    check("R8 timeout sticky", timeout, 1);
    do_start(1, 1'b0, 1'b0, 1'b0);
    check("R8 cleared on start", timeout, 0);
    run_ticks(0, reads, polls, fwo);
    check("R8 c1 single poll", polls, 1);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule